// File: doc/BRIEF.md
# Link Bring-up Reset Sequencer

This block steps an Ethernet MAC/PCS subsystem out of reset and up to a usable link. On a start request it holds the subsystem's active-low reset and waits for the subsystem's active-low reset acknowledge. Once the acknowledge arrives it releases the reset. It then waits in a fixed order: first for the transmit lanes to report stable, then for the receive PCS to report ready. When both are up it raises a ready flag, and the client logic may then start traffic.

All three status inputs come from another clock domain. Each passes through a two-flop synchronizer before the controller uses it. Every wait state is guarded by a cycle timeout that is set at a port. If a wait runs past its limit, the sequencer enters a failure state. There it keeps the subsystem in reset and raises an error flag until software or a supervisor issues a new start request. If a status input drops while the link is ready, the ready flag falls and the sequencer goes back to waiting for that status.

Top module: `lnk_bringup_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, the outputs are `state_o`=0 (IDLE), `core_rst_n_o`=0, `link_ready_o`=0 and `timeout_err_o`=0. State codes are IDLE=0, ACK_WAIT=1, TX_WAIT=2, RX_WAIT=3, LINK_UP=4, FAILED=5.
- R2: When `start_i` is high at a rising edge in IDLE, the state becomes ACK_WAIT (1) at that edge and `core_rst_n_o` stays 0.
- R3: In ACK_WAIT, the state holds and `core_rst_n_o` stays 0 as long as the synchronized `rst_ack_n_i` is 1 and the timeout has not expired.
- R4: In ACK_WAIT, a synchronized `rst_ack_n_i` of 0 moves the state to TX_WAIT (2) and drives `core_rst_n_o` to 1. `core_rst_n_o` rises only on leaving ACK_WAIT.
- R5: In TX_WAIT, `rx_pcs_ready_i` has no effect. A synchronized `tx_lanes_stable_i` of 1 moves the state to RX_WAIT (3).
- R6: In RX_WAIT, a synchronized `rx_pcs_ready_i` of 1 moves the state to LINK_UP (4). `link_ready_o` is 1 only in LINK_UP.
- R7: If a wait state (1, 2 or 3) is entered at edge E and its condition stays unmet, the state is still the same after edge E+T. Here T is the value of `timeout_cycles_i`. At edge E+T+1 the state becomes FAILED (5), with `timeout_err_o`=1 and `core_rst_n_o`=0.
- R8: In LINK_UP, a synchronized `tx_lanes_stable_i` of 0 returns the state to TX_WAIT. Otherwise, a synchronized `rx_pcs_ready_i` of 0 returns it to RX_WAIT. In both cases `link_ready_o` falls at the same edge.
- R9: A status input change applied between edges takes effect on the state at the third rising edge that follows, and not at the second.
- R10: FAILED holds regardless of status inputs until `start_i` is high at an edge. That edge moves the state to ACK_WAIT and clears `timeout_err_o`.
- R11: `start_i` has no effect in states 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| start_i | input | 1 | Request to begin (or restart) the bring-up sequence |
| rst_ack_n_i | input | 1 | Active-low reset acknowledge from the subsystem (asynchronous) |
| tx_lanes_stable_i | input | 1 | Transmit lanes stable status (asynchronous) |
| rx_pcs_ready_i | input | 1 | Receive PCS ready status (asynchronous) |
| timeout_cycles_i | input | TMO_W | Cycle limit for each wait state |
| core_rst_n_o | output | 1 | Active-low reset driven to the subsystem |
| link_ready_o | output | 1 | Link is up and traffic may start |
| state_o | output | 3 | Current sequencer state code |
| timeout_err_o | output | 1 | A wait state exceeded its timeout |

## Verification
The state code is visible at the port, so a wrong transition shows up at the next sampled cycle. A synchronizer stage that is missing or added shifts every status reaction by one edge. Comparing against the exact third edge catches such a shift at once. An off-by-one in the timeout counter moves entry into FAILED by one cycle, which an exact-cycle check finds. A wrong reset decode shows up on `core_rst_n_o` in the same cycle as the state that caused it.

// File: rtl/lnk_seq_pkg.sv
package lnk_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_ACK_WAIT = 3'd1,
        SEQ_TX_WAIT  = 3'd2,
        SEQ_RX_WAIT  = 3'd3,
        SEQ_LINK_UP  = 3'd4,
        SEQ_FAILED   = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       core_rst_n;
        logic       ready;
        logic       err;
    } seq_regs_t;

    function automatic logic is_wait_state(seq_state_e s);
        return (s == SEQ_ACK_WAIT) || (s == SEQ_TX_WAIT) || (s == SEQ_RX_WAIT);
    endfunction

    function automatic logic releases_core(seq_state_e s);
        return (s == SEQ_TX_WAIT) || (s == SEQ_RX_WAIT) || (s == SEQ_LINK_UP);
    endfunction

endpackage

// File: rtl/lnk_sync2.sv
module lnk_sync2 #(
    parameter int unsigned     W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_d, meta_q;
        logic hold_d, hold_q;

        always_comb begin
            meta_d = async_i[b];
            hold_d = meta_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                hold_q <= RST_VAL[b];
            end else begin
                meta_q <= meta_d;
                hold_q <= hold_d;
            end
        end

        assign sync_o[b] = hold_q;
    end

endmodule

// File: rtl/lnk_wait_timer.sv
module lnk_wait_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);

    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};
    localparam logic [TMO_W-1:0] CNT_ONE = {{(TMO_W-1){1'b0}}, 1'b1};

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= limit_i);

    // R7
    cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/lnk_seq_fsm.sv
module lnk_seq_fsm
    import lnk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ack_n_s,
    input  logic       tx_s,
    input  logic       rx_s,
    input  logic       expired_i,
    output logic       clr_o,
    output logic       core_rst_n_o,
    output logic       ready_o,
    output logic       err_o,
    output logic [2:0] state_o
);

    localparam seq_regs_t REGS_RST = '{
        state:      SEQ_IDLE,
        core_rst_n: 1'b0,
        ready:      1'b0,
        err:        1'b0
    };

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (start_i) r_d.state = SEQ_ACK_WAIT;
            end
            SEQ_ACK_WAIT: begin
                if (!ack_n_s)       r_d.state = SEQ_TX_WAIT;
                else if (expired_i) r_d.state = SEQ_FAILED;
            end
            SEQ_TX_WAIT: begin
                if (tx_s)           r_d.state = SEQ_RX_WAIT;
                else if (expired_i) r_d.state = SEQ_FAILED;
            end
            SEQ_RX_WAIT: begin
                if (rx_s)           r_d.state = SEQ_LINK_UP;
                else if (expired_i) r_d.state = SEQ_FAILED;
            end
            SEQ_LINK_UP: begin
                if (!tx_s)      r_d.state = SEQ_TX_WAIT;
                else if (!rx_s) r_d.state = SEQ_RX_WAIT;
            end
            SEQ_FAILED: begin
                if (start_i) r_d.state = SEQ_ACK_WAIT;
            end
            default: r_d.state = SEQ_IDLE;
        endcase
        r_d.core_rst_n = releases_core(r_d.state);
        r_d.ready      = (r_d.state == SEQ_LINK_UP);
        r_d.err        = (r_d.state == SEQ_FAILED);
        clr_o          = (r_d.state != r_q.state) || !is_wait_state(r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign core_rst_n_o = r_q.core_rst_n;
    assign ready_o      = r_q.ready;
    assign err_o        = r_q.err;
    assign state_o      = r_q.state;

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SEQ_IDLE && start_i) |=> (r_q.state == SEQ_ACK_WAIT && !r_q.core_rst_n));

    // R4
    release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.core_rst_n) |-> ($past(r_q.state) == SEQ_ACK_WAIT));

    // R7
    err_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |-> (!r_q.core_rst_n && !r_q.ready));

    // R8
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SEQ_LINK_UP && !tx_s) |=> (r_q.state == SEQ_TX_WAIT && !r_q.ready));

    // R10
    failed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SEQ_FAILED && !start_i) |=> (r_q.state == SEQ_FAILED));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SEQ_LINK_UP && tx_s && rx_s) |=> (r_q.state == SEQ_LINK_UP));

endmodule

// File: rtl/lnk_bringup_seq.sv
module lnk_bringup_seq
    import lnk_seq_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rst_ack_n_i,
    input  logic             tx_lanes_stable_i,
    input  logic             rx_pcs_ready_i,
    input  logic [TMO_W-1:0] timeout_cycles_i,
    output logic             core_rst_n_o,
    output logic             link_ready_o,
    output logic [2:0]       state_o,
    output logic             timeout_err_o
);

    localparam int unsigned  N_STAT   = 3;
    localparam logic [N_STAT-1:0] STAT_RST = 3'b001;

    logic [N_STAT-1:0] stat_raw, stat_sync;
    logic              tmr_clr, tmr_expired;

    assign stat_raw = {rx_pcs_ready_i, tx_lanes_stable_i, rst_ack_n_i};

    lnk_sync2 #(
        .W       (N_STAT),
        .RST_VAL (STAT_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stat_raw),
        .sync_o  (stat_sync)
    );

    lnk_wait_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .limit_i   (timeout_cycles_i),
        .expired_o (tmr_expired)
    );

    lnk_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .ack_n_s      (stat_sync[0]),
        .tx_s         (stat_sync[1]),
        .rx_s         (stat_sync[2]),
        .expired_i    (tmr_expired),
        .clr_o        (tmr_clr),
        .core_rst_n_o (core_rst_n_o),
        .ready_o      (link_ready_o),
        .err_o        (timeout_err_o),
        .state_o      (state_o)
    );

    // R6
    ready_only_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready_o |-> (state_o == 3'd4 && core_rst_n_o));

endmodule

// File: tb/sim_lnk_bringup_seq.sv
module sim_lnk_bringup_seq;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i, ack_n, tx_st, rx_rdy;
    logic [TW-1:0] tmo;
    logic          core_rst_n, link_ready, tmo_err;
    logic [2:0]    state;

    always #2 clk = ~clk;

    lnk_bringup_seq #(.TMO_W(TW)) u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_i           (start_i),
        .rst_ack_n_i       (ack_n),
        .tx_lanes_stable_i (tx_st),
        .rx_pcs_ready_i    (rx_rdy),
        .timeout_cycles_i  (tmo),
        .core_rst_n_o      (core_rst_n),
        .link_ready_o      (link_ready),
        .state_o           (state),
        .timeout_err_o     (tmo_err)
    );

    typedef struct {
        logic [2:0] st;
        logic       rst;
        logic       rdy;
        logic       err;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [2:0] st, input logic rst, input logic rdy,
                              input logic err, input string tag);
        exp_t e;
        e.st = st; e.rst = rst; e.rdy = rdy; e.err = err; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        tick(1);
        start_i = 1'b0;
    endtask

    // monitor: compares outputs against queued expectations, 1 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (state !== e.st || core_rst_n !== e.rst || link_ready !== e.rdy || tmo_err !== e.err) begin
                    bad++;
                    $display("FAIL %s: actual st=%0d rst_n=%0b rdy=%0b err=%0b expected st=%0d rst_n=%0b rdy=%0b err=%0b",
                             e.tag, state, core_rst_n, link_ready, tmo_err, e.st, e.rst, e.rdy, e.err);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; ack_n = 1'b1; tx_st = 1'b0; rx_rdy = 1'b0;
        tmo = 16'd20;
        tick(3);
        expect_out(3'd0, 1'b0, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        tick(1);
        expect_out(3'd0, 1'b0, 1'b0, 1'b0, "R1 after release");

        // R2: start from IDLE
        pulse_start();
        expect_out(3'd1, 1'b0, 1'b0, 1'b0, "R2");
        // R3: ack still high
        tick(6);
        expect_out(3'd1, 1'b0, 1'b0, 1'b0, "R3");
        // R9 / R4: ack falls, effect at third edge
        ack_n = 1'b0;
        tick(2);
        expect_out(3'd1, 1'b0, 1'b0, 1'b0, "R9 ack second edge");
        tick(1);
        expect_out(3'd2, 1'b1, 1'b0, 1'b0, "R4");

        // R5: rx ready ignored before tx stable
        rx_rdy = 1'b1;
        tick(4);
        expect_out(3'd2, 1'b1, 1'b0, 1'b0, "R5 rx ignored");
        tx_st = 1'b1;
        tick(2);
        expect_out(3'd2, 1'b1, 1'b0, 1'b0, "R9 tx second edge");
        tick(1);
        expect_out(3'd3, 1'b1, 1'b0, 1'b0, "R5 tx stable");
        tick(1);
        expect_out(3'd4, 1'b1, 1'b1, 1'b0, "R6 link up");

        // R11: start ignored in LINK_UP
        pulse_start();
        tick(2);
        expect_out(3'd4, 1'b1, 1'b1, 1'b0, "R11");

        // R8: rx drop then recover
        rx_rdy = 1'b0;
        tick(3);
        expect_out(3'd3, 1'b1, 1'b0, 1'b0, "R8 rx drop");
        rx_rdy = 1'b1;
        tick(3);
        expect_out(3'd4, 1'b1, 1'b1, 1'b0, "R6 relink");

        // R8 then R7: tx drop, stays low until timeout
        tmo = 16'd5;
        tx_st = 1'b0;
        tick(3);
        expect_out(3'd2, 1'b1, 1'b0, 1'b0, "R8 tx drop");
        tick(5);
        expect_out(3'd2, 1'b1, 1'b0, 1'b0, "R7 tx wait edge T");
        tick(1);
        expect_out(3'd5, 1'b0, 1'b0, 1'b1, "R7 tx timeout");

        // R10: FAILED ignores status
        tx_st = 1'b1;
        ack_n = 1'b1;
        tick(5);
        expect_out(3'd5, 1'b0, 1'b0, 1'b1, "R10 hold");
        pulse_start();
        expect_out(3'd1, 1'b0, 1'b0, 1'b0, "R10 restart");

        // R7: timeout in ACK_WAIT
        tick(5);
        expect_out(3'd1, 1'b0, 1'b0, 1'b0, "R7 ack wait edge T");
        tick(1);
        expect_out(3'd5, 1'b0, 1'b0, 1'b1, "R7 ack timeout");

        // R7: timeout in RX_WAIT
        ack_n = 1'b0;
        rx_rdy = 1'b0;
        tick(3);
        pulse_start();
        expect_out(3'd1, 1'b0, 1'b0, 1'b0, "R10 restart 2");
        tick(1);
        expect_out(3'd2, 1'b1, 1'b0, 1'b0, "R4 fast ack");
        tick(1);
        expect_out(3'd3, 1'b1, 1'b0, 1'b0, "R5 fast tx");
        tick(5);
        expect_out(3'd3, 1'b1, 1'b0, 1'b0, "R7 rx wait edge T");
        tick(1);
        expect_out(3'd5, 1'b0, 1'b0, 1'b1, "R7 rx timeout");

        tick(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule